// File: doc/BRIEF.md
# Per-Destination Packet-Count Loss Detector

This block sits at the sending end of a link and finds silent loss that a liveness exchange cannot see. Examples are random drops, or drops that hit only a few destination prefixes. It keeps one packet counter for each destination index. A counter advances only while a measurement window is open. A start marker opens the window and clears all state. A stop marker closes the window.

Once the window is closed, the far end of the link returns its own per-destination counts as a stream of index/count entries. These are the packets it received and forwarded. The block compares each entry with its local counter. Any difference marks that destination as failing in a sticky bitmap. The first difference in a campaign also raises a one-cycle alert. When every destination index has been compared, the block emits a one-cycle done pulse and stops accepting entries until the next start marker.

Control is a four-state machine:
- `ST_IDLE` is the state after reset.
- `ST_COUNT` means the window is open.
- `ST_COLLECT` means the window is closed and report entries are accepted.
- `ST_CHECKED` means every index has been compared.

Transitions:
- A start marker moves any state to `ST_COUNT`.
- `ST_COUNT` goes to `ST_COLLECT` on a stop marker.
- `ST_COLLECT` goes to `ST_CHECKED` on the entry that completes coverage.
- In every other case the state holds.

Top module: `lossdet_top`

## Requirements
- R1: After reset, the window is closed, and `fail_map_o`, `alert_o` and `done_o` are all zero.
- R2: A start marker acts from any state. It clears every counter and the failure bitmap, and `window_open_o` is high from the next cycle. When start and stop are asserted together, start takes precedence.
- R3: While the window is open, each cycle with `pkt_valid_i` high adds one to the counter selected by `pkt_dest_i`. Packets presented while the window is closed, before a start marker or after a stop marker, change no counter.
- R4: A stop marker with the window open closes the window on the next cycle and begins collection. Report entries presented while the window is open are ignored.
- R5: During collection, an entry whose count differs from the local counter of its index sets bit `rpt_idx_i` of `fail_map_o` on the next cycle. An entry whose count is equal leaves that bit clear. Each destination is judged on its own, and a higher far-end count is also a mismatch.
- R6: `alert_o` is high for exactly one cycle, the cycle after the first mismatching entry of a campaign. Later mismatches in the same campaign do not raise it again.
- R7: Bits set in `fail_map_o` stay set until the next start marker.
- R8: `done_o` is high for exactly one cycle, the cycle after the entry that makes every index from 0 to NUM_DEST-1 compared at least once. Entries after that, until the next start marker, are ignored.
- R9: An entry whose `rpt_idx_i` (IDX_W+1 bits wide) is NUM_DEST or above is ignored. It sets no failure bit and counts toward no coverage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Campaign start marker: clear and open the window |
| stop_i | input | 1 | Campaign stop marker: close the window |
| pkt_valid_i | input | 1 | A packet is being sent this cycle |
| pkt_dest_i | input | IDX_W | Destination index of the packet |
| rpt_valid_i | input | 1 | A far-end report entry is present |
| rpt_idx_i | input | IDX_W+1 | Destination index of the report entry |
| rpt_count_i | input | CNT_W | Far-end received-and-forwarded count |
| window_open_o | output | 1 | Measurement window is open |
| fail_map_o | output | NUM_DEST | Sticky per-destination mismatch bitmap |
| alert_o | output | 1 | One-cycle pulse on the first mismatch of a campaign |
| done_o | output | 1 | One-cycle pulse when all indices are compared |

## Verification
The assertions check several properties on every cycle:
- After a start marker, the bitmap is clear and the window is open.
- The window never opens without a start marker.
- The bitmap stays zero while the window is open.
- Set bits never drop without a start marker.
- `alert_o` and `done_o` never last two cycles.
- Out-of-range entries leave the bitmap untouched.

Some behaviours can only be shown by the bench's scenarios, because they depend on the counts:
- That each mismatch lands on the right bit.
- That equal counts raise nothing.
- That packets outside the window are not counted.
- That the done pulse appears exactly on the entry completing coverage and not earlier.

// File: rtl/lossdet_pkg.sv
package lossdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_COLLECT,
        ST_CHECKED
    } ld_state_e;

endpackage

// File: rtl/lossdet_fsm.sv
module lossdet_fsm
    import lossdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic cover_done_i,
    output logic clear_o,
    output logic count_en_o,
    output logic collect_en_o
);

    ld_state_e state_q;
    ld_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (start_i)     state_d = ST_COUNT;
                else if (stop_i) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (start_i)           state_d = ST_COUNT;
                else if (cover_done_i) state_d = ST_CHECKED;
            end
            ST_CHECKED: begin
                if (start_i) state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clear_o      = start_i;
        count_en_o   = 1'b0;
        collect_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COUNT:   count_en_o   = 1'b1;
            ST_COLLECT: collect_en_o = !start_i;
            ST_CHECKED: ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/lossdet_counters.sv
module lossdet_counters #(
    parameter int NUM_DEST = 16,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             count_en_i,
    input  logic             pkt_valid_i,
    input  logic [IDX_W-1:0] pkt_dest_i,
    output logic [CNT_W-1:0] cnt_o [NUM_DEST]
);

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_cnt
        logic bump;
        assign bump = count_en_i && pkt_valid_i && (pkt_dest_i == IDX_W'(d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_o[d] <= '0;
            end else if (clear_i) begin
                cnt_o[d] <= '0;
            end else if (bump) begin
                cnt_o[d] <= cnt_o[d] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lossdet_compare.sv
module lossdet_compare #(
    parameter int NUM_DEST = 16,
    parameter int CNT_W    = 16,
    parameter int RIDX_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                collect_en_i,
    input  logic                rpt_valid_i,
    input  logic [RIDX_W-1:0]   rpt_idx_i,
    input  logic [CNT_W-1:0]    rpt_count_i,
    input  logic [CNT_W-1:0]    cnt_i [NUM_DEST],
    output logic                cover_done_o,
    output logic [NUM_DEST-1:0] fail_map_o,
    output logic                alert_o,
    output logic                done_o
);

    logic [NUM_DEST-1:0] hit;
    logic [NUM_DEST-1:0] seen_q;
    logic [NUM_DEST-1:0] seen_d;
    logic [CNT_W-1:0]    local_cnt;
    logic                accept;
    logic                mismatch;

    // Select the local counter of the report index; hit stays zero if out of range
    always_comb begin
        hit       = '0;
        local_cnt = '0;
        for (int d = 0; d < NUM_DEST; d++) begin
            if (rpt_valid_i && collect_en_i && (rpt_idx_i == RIDX_W'(d))) begin
                hit[d]    = 1'b1;
                local_cnt = cnt_i[d];
            end
        end
    end

    assign accept       = |hit;
    assign mismatch     = accept && (local_cnt != rpt_count_i);
    assign seen_d       = seen_q | hit;
    assign cover_done_o = accept && (&seen_d) && !(&seen_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= '0;
            fail_map_o <= '0;
            alert_o    <= 1'b0;
            done_o     <= 1'b0;
        end else if (clear_i) begin
            seen_q     <= '0;
            fail_map_o <= '0;
            alert_o    <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            seen_q  <= seen_d;
            alert_o <= mismatch && !(|fail_map_o);
            done_o  <= cover_done_o;
            if (mismatch) begin
                fail_map_o <= fail_map_o | hit;
            end
        end
    end

endmodule

// File: rtl/lossdet_top.sv
module lossdet_top #(
    parameter  int NUM_DEST = 16,
    parameter  int CNT_W    = 16,
    localparam int IDX_W    = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int RIDX_W   = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                pkt_valid_i,
    input  logic [IDX_W-1:0]    pkt_dest_i,
    input  logic                rpt_valid_i,
    input  logic [RIDX_W-1:0]   rpt_idx_i,
    input  logic [CNT_W-1:0]    rpt_count_i,
    output logic                window_open_o,
    output logic [NUM_DEST-1:0] fail_map_o,
    output logic                alert_o,
    output logic                done_o
);

    logic             clear;
    logic             count_en;
    logic             collect_en;
    logic             cover_done;
    logic [CNT_W-1:0] cnt [NUM_DEST];

    lossdet_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .cover_done_i (cover_done),
        .clear_o      (clear),
        .count_en_o   (count_en),
        .collect_en_o (collect_en)
    );

    lossdet_counters #(
        .NUM_DEST (NUM_DEST),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_counters (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .count_en_i  (count_en),
        .pkt_valid_i (pkt_valid_i),
        .pkt_dest_i  (pkt_dest_i),
        .cnt_o       (cnt)
    );

    lossdet_compare #(
        .NUM_DEST (NUM_DEST),
        .CNT_W    (CNT_W),
        .RIDX_W   (RIDX_W)
    ) u_compare (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .collect_en_i (collect_en),
        .rpt_valid_i  (rpt_valid_i),
        .rpt_idx_i    (rpt_idx_i),
        .rpt_count_i  (rpt_count_i),
        .cnt_i        (cnt),
        .cover_done_o (cover_done),
        .fail_map_o   (fail_map_o),
        .alert_o      (alert_o),
        .done_o       (done_o)
    );

    assign window_open_o = count_en;

endmodule

// File: rtl/lossdet_checker.sv
module lossdet_checker #(
    parameter  int NUM_DEST = 16,
    localparam int IDX_W    = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int RIDX_W   = IDX_W + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                rpt_valid_i,
    input logic [RIDX_W-1:0]   rpt_idx_i,
    input logic                window_open_o,
    input logic [NUM_DEST-1:0] fail_map_o,
    input logic                alert_o,
    input logic                done_o
);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (window_open_o && (fail_map_o == '0)));

    a_r2_open_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !window_open_o) |=> !window_open_o);

    a_r4_no_fail_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        window_open_o |-> (fail_map_o == '0));

    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ((fail_map_o & $past(fail_map_o)) == $past(fail_map_o)));

    a_r6_alert_single: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |=> !alert_o);

    a_r6_alert_has_fail: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |-> ($countones(fail_map_o) >= 1));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid_i && (rpt_idx_i >= RIDX_W'(NUM_DEST)) && !start_i)
            |=> (fail_map_o == $past(fail_map_o)));

endmodule

bind lossdet_top lossdet_checker #(.NUM_DEST(NUM_DEST)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rpt_valid_i   (rpt_valid_i),
    .rpt_idx_i     (rpt_idx_i),
    .window_open_o (window_open_o),
    .fail_map_o    (fail_map_o),
    .alert_o       (alert_o),
    .done_o        (done_o)
);

// File: tb/lossdet_top_tb_top.sv
module lossdet_top_tb_top;

    localparam int ND = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          pkt_valid_i = 1'b0;
    logic [3:0]    pkt_dest_i = '0;
    logic          rpt_valid_i = 1'b0;
    logic [4:0]    rpt_idx_i = '0;
    logic [CW-1:0] rpt_count_i = '0;
    logic          window_open_o;
    logic [ND-1:0] fail_map_o;
    logic          alert_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;
    int alert_n = 0;
    int done_n = 0;

    // Per destination: packets sent [16:9], far-end count [8:1], expected fail [0]
    localparam logic [16:0] VEC [16] = '{
        {8'd3, 8'd3, 1'b0}, {8'd0, 8'd0, 1'b0}, {8'd5, 8'd4, 1'b1}, {8'd1, 8'd1, 1'b0},
        {8'd7, 8'd7, 1'b0}, {8'd2, 8'd0, 1'b1}, {8'd4, 8'd4, 1'b0}, {8'd6, 8'd6, 1'b0},
        {8'd1, 8'd2, 1'b1}, {8'd0, 8'd0, 1'b0}, {8'd3, 8'd3, 1'b0}, {8'd5, 8'd5, 1'b0},
        {8'd2, 8'd2, 1'b0}, {8'd4, 8'd4, 1'b0}, {8'd6, 8'd6, 1'b0}, {8'd1, 8'd1, 1'b0}
    };

    always #4 clk = ~clk;

    lossdet_top #(.NUM_DEST(ND), .CNT_W(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .pkt_valid_i   (pkt_valid_i),
        .pkt_dest_i    (pkt_dest_i),
        .rpt_valid_i   (rpt_valid_i),
        .rpt_idx_i     (rpt_idx_i),
        .rpt_count_i   (rpt_count_i),
        .window_open_o (window_open_o),
        .fail_map_o    (fail_map_o),
        .alert_o       (alert_o),
        .done_o        (done_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (alert_o) alert_n++;
        if (done_o)  done_n++;
    endtask

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic do_stop();
        stop_i = 1'b1; tick(); stop_i = 1'b0;
    endtask

    task automatic send_pkt(int d);
        pkt_valid_i = 1'b1; pkt_dest_i = 4'(d); tick(); pkt_valid_i = 1'b0;
    endtask

    task automatic send_rpt(int idx, int cnt);
        rpt_valid_i = 1'b1; rpt_idx_i = 5'(idx); rpt_count_i = CW'(cnt);
        tick();
        rpt_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [ND-1:0] exp_map;
        repeat (3) tick();
        check("R1 window", window_open_o, 0);
        check("R1 fail_map", fail_map_o, 0);
        check("R1 alert", alert_o, 0);
        check("R1 done", done_o, 0);
        rst_n = 1'b1;
        tick();

        // Packets before any start are not counted (R3)
        send_pkt(3); send_pkt(3);

        // Table campaign
        do_start();
        check("R2 window open", window_open_o, 1);
        for (int r = 0; r < 8; r++)
            for (int d = 0; d < ND; d++)
                if (r < int'(VEC[d][16:9])) send_pkt(d);
        do_stop();
        check("R4 window closed", window_open_o, 0);
        alert_n = 0; done_n = 0;
        for (int d = 0; d < ND; d++) begin
            if (d == ND - 1) check("R8 no early done", done_n, 0);
            send_rpt(d, int'(VEC[d][8:1]));
        end
        check("R8 done once", done_n, 1);
        check("R6 alert once", alert_n, 1);
        exp_map = '0;
        for (int d = 0; d < ND; d++) begin
            exp_map[d] = VEC[d][0];
            check($sformatf("R5 dest %0d", d), fail_map_o[d], VEC[d][0]);
        end
        repeat (5) tick();
        check("R7 sticky map", fail_map_o, exp_map);
        check("R8 single done", done_n, 1);

        // Out-of-range entries (R9) and clearing (R2)
        do_start();
        check("R2 map cleared", fail_map_o, 0);
        send_pkt(0); send_pkt(0);
        do_stop();
        alert_n = 0; done_n = 0;
        send_rpt(16, 99);
        send_rpt(31, 7);
        check("R9 no fail", fail_map_o, 0);
        for (int d = 1; d < ND; d++) send_rpt(d, 0);
        check("R9 no coverage", done_n, 0);
        send_rpt(0, 2);
        check("R9 done after idx0", done_n, 1);
        check("R9 map clear", fail_map_o, 0);
        check("R5 equal no alert", alert_n, 0);

        // Window edges (R3, R4, R8)
        do_start();
        send_pkt(5); send_pkt(5); send_pkt(5);
        send_rpt(5, 0);
        check("R4 report in window ignored", fail_map_o, 0);
        do_stop();
        send_pkt(5); send_pkt(5); send_pkt(5); send_pkt(5);
        alert_n = 0; done_n = 0;
        for (int d = 0; d < ND; d++) send_rpt(d, (d == 5) ? 3 : 0);
        check("R3 post-stop packets ignored", fail_map_o, 0);
        check("R3 done", done_n, 1);
        send_rpt(5, 9);
        tick();
        check("R8 late entry ignored", fail_map_o, 0);
        check("R8 late entry no alert", alert_n, 0);

        // Start wins over stop (R2)
        start_i = 1'b1; stop_i = 1'b1; tick();
        start_i = 1'b0; stop_i = 1'b0;
        check("R2 start precedence", window_open_o, 1);
        do_stop();
        check("R4 stop closes", window_open_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule